// File: doc/BRIEF.md
# Interrupt Pin Edge Message Generator

This block watches a set of level interrupt pins and turns each new assertion of a pin into one interrupt message. Every pin has a configuration entry, given as parallel inputs: a mask bit, a vector, a destination, a delivery mode, a destination mode, a polarity and a trigger mode. A pin that goes from its stored low state to high, while its entry is unmasked, becomes pending. The block serves pending pins one at a time, lowest index first, and builds a message from the selected pin's entry.

When the entry selects the external-interrupt delivery mode, the vector does not come from the entry. The block first runs a request/acknowledge exchange with an outside legacy interrupt controller and uses the vector returned with the acknowledge. Messages leave on a valid/ready port. Deciding which processors receive a message is left to the logic downstream.

The reset input is asynchronous and active-low. Inside the block it is released synchronously through a two-stage synchronizer, so the block starts to track its pins two clock edges after reset is released.

Top module: `irq_edge_msg_gen`

## Requirements
- R1: A pin produces a message only when its stored state was low and the pin is sampled high. The stored state then follows the pin, so a pin held high never produces a second message.
- R2: A pin going low only clears its stored state and produces no message. A later new assertion of the same pin produces a new message.
- R3: If a pin's mask bit is 1 in the cycle of its new assertion, the event is dropped. Clearing the mask later while the pin stays high produces no message.
- R4: Delivery mode encodings are 0 fixed, 1 lowest priority, 2 SMI, 4 NMI, 5 INIT and 7 external interrupt. In every mode except 7, the message vector equals the entry vector.
- R5: In delivery mode 7, `ext_req_o` rises and stays high until `ext_ack_i` is seen. No message is presented before the acknowledge arrives, and the message vector is the `ext_vec_i` value sampled with the acknowledge.
- R6: When several pins have events pending, the lowest-numbered pin is served first. The others stay pending and are served later in ascending order, one message each.
- R7: The message carries the entry's destination, delivery mode and destination mode. The entry polarity becomes the message level and the entry trigger mode becomes the message trigger. All fields stay stable while `msg_valid_o` is high and `msg_ready_i` is low.
- R8: During reset `msg_valid_o` and `ext_req_o` are low and all stored pin states are low. A pin already high when reset ends therefore produces exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Interrupt pin levels |
| ent_mask_i | input | NUM_PINS | Per-pin mask bit |
| ent_vec_i | input | NUM_PINS*VEC_W | Per-pin vector, pin p at bits [p*VEC_W +: VEC_W] |
| ent_dest_i | input | NUM_PINS*DEST_W | Per-pin destination |
| ent_dmode_i | input | NUM_PINS*3 | Per-pin delivery mode |
| ent_dstmode_i | input | NUM_PINS | Per-pin destination mode |
| ent_pol_i | input | NUM_PINS | Per-pin polarity |
| ent_trig_i | input | NUM_PINS | Per-pin trigger mode |
| ext_req_o | output | 1 | Vector request to the external controller |
| ext_ack_i | input | 1 | Vector acknowledge from the external controller |
| ext_vec_i | input | VEC_W | Vector returned with the acknowledge |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the consumer |
| msg_dest_o | output | DEST_W | Message destination |
| msg_vec_o | output | VEC_W | Message vector |
| msg_dmode_o | output | 3 | Message delivery mode |
| msg_dstmode_o | output | 1 | Message destination mode |
| msg_level_o | output | 1 | Message level, taken from the entry polarity |
| msg_trig_o | output | 1 | Message trigger mode |

## Verification
The assertions check on every cycle four things:
- a pending bit only rises after a low stored state and an unmasked entry;
- a pending bit only falls when the engine takes that pin;
- the vector request holds until it is acknowledged and never overlaps a valid message;
- a waiting message keeps its fields.

Only the bench scenarios can show the rest:
- the field values carried by each message, and the choice between the entry vector and the external vector;
- the ascending service order of simultaneous events;
- that masked events stay lost after unmasking, that held pins stay silent, and that a pin high through reset fires once.

// File: rtl/irq_msg_pkg.sv
`timescale 1ns/1ps
package irq_msg_pkg;

  localparam int DMODE_W = 3;

  typedef enum logic [DMODE_W-1:0] {
    DM_FIXED  = 3'd0,
    DM_LOWPRI = 3'd1,
    DM_SMI    = 3'd2,
    DM_NMI    = 3'd4,
    DM_INIT   = 3'd5,
    DM_EXTINT = 3'd7
  } dmode_e;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_FETCH = 2'd1,
    ENG_SEND  = 2'd2
  } eng_state_e;

endpackage

// File: rtl/irq_pin_tracker.sv
`timescale 1ns/1ps
// Per-pin stored level and pending-event bit.
module irq_pin_tracker #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic [NUM_PINS-1:0] clr_i,
  output logic [NUM_PINS-1:0] pend_o
);

  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] pend_q;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic new_evt;
    logic pend_d;

    always_comb begin
      new_evt = pin_i[p] & ~lvl_q[p] & ~mask_i[p];
      pend_d  = (pend_q[p] & ~clr_i[p]) | new_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q[p]  <= 1'b0;
        pend_q[p] <= 1'b0;
      end else begin
        lvl_q[p]  <= pin_i[p];
        pend_q[p] <= pend_d;
      end
    end

    // A pending bit appears only after a low stored level
    assert_no_refire_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[p]) |-> !$past(lvl_q[p]));

    // A pending bit never comes from a masked entry
    assert_mask_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[p]) |-> !$past(mask_i[p]));

    // Pending events leave only when served
    assert_pend_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pend_q[p]) |-> $past(clr_i[p]));
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_lowest_pick.sv
`timescale 1ns/1ps
// Lowest-index selection among pending pins.
module irq_lowest_pick #(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic                any_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [NUM_PINS-1:0] oh_o
);

  always_comb begin
    any_o = |pend_i;
    oh_o  = pend_i & (~pend_i + 1'b1);
    idx_o = '0;
    for (int p = NUM_PINS - 1; p >= 0; p--) begin
      if (pend_i[p]) idx_o = IDX_W'(p);
    end
  end

endmodule

// File: rtl/irq_msg_engine.sv
`timescale 1ns/1ps
// Message assembly, external vector fetch and output handshake.
module irq_msg_engine
  import irq_msg_pkg::*;
#(
  parameter int DEST_W = 8,
  parameter int VEC_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cand_valid_i,
  input  logic [DEST_W-1:0]  cand_dest_i,
  input  logic [VEC_W-1:0]   cand_vec_i,
  input  logic [DMODE_W-1:0] cand_dmode_i,
  input  logic               cand_dstmode_i,
  input  logic               cand_pol_i,
  input  logic               cand_trig_i,
  output logic               take_o,
  output logic               ext_req_o,
  input  logic               ext_ack_i,
  input  logic [VEC_W-1:0]   ext_vec_i,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [DEST_W-1:0]  msg_dest_o,
  output logic [VEC_W-1:0]   msg_vec_o,
  output logic [DMODE_W-1:0] msg_dmode_o,
  output logic               msg_dstmode_o,
  output logic               msg_level_o,
  output logic               msg_trig_o
);

  eng_state_e state_q, state_d;
  logic       is_ext;
  logic       ld_fields;
  logic       ld_ext_vec;

  logic [DEST_W-1:0]  dest_q;
  logic [VEC_W-1:0]   vec_q;
  logic [DMODE_W-1:0] dmode_q;
  logic               dstmode_q, level_q, trig_q;

  always_comb begin
    is_ext     = (cand_dmode_i == DM_EXTINT);
    ld_fields  = (state_q == ENG_IDLE) && cand_valid_i;
    ld_ext_vec = (state_q == ENG_FETCH) && ext_ack_i;
    state_d    = state_q;
    case (state_q)
      ENG_IDLE:  if (cand_valid_i) state_d = is_ext ? ENG_FETCH : ENG_SEND;
      ENG_FETCH: if (ext_ack_i)    state_d = ENG_SEND;
      ENG_SEND:  if (msg_ready_i)  state_d = ENG_IDLE;
      default:                     state_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ENG_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q    <= '0;
      dmode_q   <= '0;
      dstmode_q <= 1'b0;
      level_q   <= 1'b0;
      trig_q    <= 1'b0;
    end else if (ld_fields) begin
      dest_q    <= cand_dest_i;
      dmode_q   <= cand_dmode_i;
      dstmode_q <= cand_dstmode_i;
      level_q   <= cand_pol_i;
      trig_q    <= cand_trig_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          vec_q <= '0;
    else if (ld_fields)  vec_q <= cand_vec_i;
    else if (ld_ext_vec) vec_q <= ext_vec_i;
  end

  assign take_o        = ld_fields;
  assign ext_req_o     = (state_q == ENG_FETCH);
  assign msg_valid_o   = (state_q == ENG_SEND);
  assign msg_dest_o    = dest_q;
  assign msg_vec_o     = vec_q;
  assign msg_dmode_o   = dmode_q;
  assign msg_dstmode_o = dstmode_q;
  assign msg_level_o   = level_q;
  assign msg_trig_o    = trig_q;

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_o && !ext_ack_i) |=> ext_req_o);

  assert_no_msg_in_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_req_o && msg_valid_o));

  assert_msg_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable(msg_vec_o)
      && $stable(msg_dest_o) && $stable(msg_dmode_o) && $stable(msg_level_o)));

endmodule

// File: rtl/irq_edge_msg_gen.sv
`timescale 1ns/1ps
module irq_edge_msg_gen
  import irq_msg_pkg::*;
#(
  parameter int NUM_PINS = 8,
  parameter int DEST_W   = 8,
  parameter int VEC_W    = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          pin_i,
  input  logic [NUM_PINS-1:0]          ent_mask_i,
  input  logic [NUM_PINS*VEC_W-1:0]    ent_vec_i,
  input  logic [NUM_PINS*DEST_W-1:0]   ent_dest_i,
  input  logic [NUM_PINS*DMODE_W-1:0]  ent_dmode_i,
  input  logic [NUM_PINS-1:0]          ent_dstmode_i,
  input  logic [NUM_PINS-1:0]          ent_pol_i,
  input  logic [NUM_PINS-1:0]          ent_trig_i,
  output logic                         ext_req_o,
  input  logic                         ext_ack_i,
  input  logic [VEC_W-1:0]             ext_vec_i,
  output logic                         msg_valid_o,
  input  logic                         msg_ready_i,
  output logic [DEST_W-1:0]            msg_dest_o,
  output logic [VEC_W-1:0]             msg_vec_o,
  output logic [DMODE_W-1:0]           msg_dmode_o,
  output logic                         msg_dstmode_o,
  output logic                         msg_level_o,
  output logic                         msg_trig_o
);

  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

  // Reset synchronizer: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [NUM_PINS-1:0] pend;
  logic [NUM_PINS-1:0] grant_oh;
  logic [NUM_PINS-1:0] clr;
  logic                any_pend;
  logic [IDX_W-1:0]    sel_idx;
  logic                take;

  logic [DEST_W-1:0]   sel_dest;
  logic [VEC_W-1:0]    sel_vec;
  logic [DMODE_W-1:0]  sel_dmode;
  logic                sel_dstmode, sel_pol, sel_trig;

  irq_pin_tracker #(.NUM_PINS(NUM_PINS)) tracker_i (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .pin_i  (pin_i),
    .mask_i (ent_mask_i),
    .clr_i  (clr),
    .pend_o (pend)
  );

  irq_lowest_pick #(.NUM_PINS(NUM_PINS)) pick_i (
    .pend_i (pend),
    .any_o  (any_pend),
    .idx_o  (sel_idx),
    .oh_o   (grant_oh)
  );

  always_comb begin
    sel_dest    = ent_dest_i[sel_idx*DEST_W +: DEST_W];
    sel_vec     = ent_vec_i[sel_idx*VEC_W +: VEC_W];
    sel_dmode   = ent_dmode_i[sel_idx*DMODE_W +: DMODE_W];
    sel_dstmode = ent_dstmode_i[sel_idx];
    sel_pol     = ent_pol_i[sel_idx];
    sel_trig    = ent_trig_i[sel_idx];
    clr         = take ? grant_oh : '0;
  end

  irq_msg_engine #(.DEST_W(DEST_W), .VEC_W(VEC_W)) engine_i (
    .clk            (clk),
    .rst_n          (rst_n_int),
    .cand_valid_i   (any_pend),
    .cand_dest_i    (sel_dest),
    .cand_vec_i     (sel_vec),
    .cand_dmode_i   (sel_dmode),
    .cand_dstmode_i (sel_dstmode),
    .cand_pol_i     (sel_pol),
    .cand_trig_i    (sel_trig),
    .take_o         (take),
    .ext_req_o      (ext_req_o),
    .ext_ack_i      (ext_ack_i),
    .ext_vec_i      (ext_vec_i),
    .msg_valid_o    (msg_valid_o),
    .msg_ready_i    (msg_ready_i),
    .msg_dest_o     (msg_dest_o),
    .msg_vec_o      (msg_vec_o),
    .msg_dmode_o    (msg_dmode_o),
    .msg_dstmode_o  (msg_dstmode_o),
    .msg_level_o    (msg_level_o),
    .msg_trig_o     (msg_trig_o)
  );

  // Each take serves exactly one pending pin
  assert_single_take_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    take |-> $countones(clr) == 1);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !rst_n_int |-> (!msg_valid_o && !ext_req_o));

endmodule

// File: tb/irq_edge_msg_gen_tb_top.sv
`timescale 1ns/1ps
module irq_edge_msg_gen_tb_top;

  localparam int N  = 8;
  localparam int DW = 8;
  localparam int VW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    pin;
  logic [N-1:0]    mask;
  logic [VW-1:0]   e_vec  [N];
  logic [DW-1:0]   e_dest [N];
  logic [2:0]      e_dm   [N];
  logic [N*VW-1:0] vec_flat;
  logic [N*DW-1:0] dest_flat;
  logic [N*3-1:0]  dm_flat;
  logic [N-1:0]    dstm, pol, trig;
  logic            ext_req, ext_ack;
  logic [VW-1:0]   ext_vec;
  logic            m_valid, m_ready;
  logic [DW-1:0]   m_dest;
  logic [VW-1:0]   m_vec;
  logic [2:0]      m_dm;
  logic            m_dstm, m_lvl, m_trig;

  int tests  = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int p = 0; p < N; p++) begin
      vec_flat[p*VW +: VW]  = e_vec[p];
      dest_flat[p*DW +: DW] = e_dest[p];
      dm_flat[p*3 +: 3]     = e_dm[p];
    end
  end

  irq_edge_msg_gen #(.NUM_PINS(N), .DEST_W(DW), .VEC_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .ent_mask_i(mask),
    .ent_vec_i(vec_flat), .ent_dest_i(dest_flat), .ent_dmode_i(dm_flat),
    .ent_dstmode_i(dstm), .ent_pol_i(pol), .ent_trig_i(trig),
    .ext_req_o(ext_req), .ext_ack_i(ext_ack), .ext_vec_i(ext_vec),
    .msg_valid_o(m_valid), .msg_ready_i(m_ready), .msg_dest_o(m_dest),
    .msg_vec_o(m_vec), .msg_dmode_o(m_dm), .msg_dstmode_o(m_dstm),
    .msg_level_o(m_lvl), .msg_trig_o(m_trig)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // No message may appear for n cycles
  task automatic quiet(input int n, input string req);
    bit seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (m_valid) seen = 1'b1;
    end
    chk(!seen, req, {31'd0, seen}, 32'd0);
  endtask

  // Wait for a message, check it stays put, accept it
  task automatic take_msg(input int p, input logic [2:0] dm,
                          input logic [VW-1:0] ev, input string req);
    bit got = 1'b0;
    logic [31:0] act, exp;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      if (m_valid) got = 1'b1;
    end
    chk(got, {req, " valid"}, {31'd0, got}, 32'd1);
    exp = {6'd0, e_dest[p], ev, dm, dstm[p], pol[p], trig[p]};
    act = {6'd0, m_dest, m_vec, m_dm, m_dstm, m_lvl, m_trig};
    chk(act == exp, {req, " fields"}, act, exp);
    step(2);
    act = {6'd0, m_dest, m_vec, m_dm, m_dstm, m_lvl, m_trig};
    chk(m_valid && act == exp, "R7 held stable", act, exp);
    m_ready = 1'b1;
    step(1);
    m_ready = 1'b0;
  endtask

  // Answer an external vector request after a delay
  task automatic ext_serve(input logic [VW-1:0] v);
    bit got = 1'b0;
    bit early = 1'b0;
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      if (ext_req) got = 1'b1;
      if (m_valid) early = 1'b1;
    end
    chk(got, "R5 request raised", {31'd0, got}, 32'd1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (m_valid || !ext_req) early = 1'b1;
    end
    chk(!early, "R5 wait for ack", {31'd0, early}, 32'd0);
    ext_ack = 1'b1;
    ext_vec = v;
    step(1);
    ext_ack = 1'b0;
    ext_vec = '0;
  endtask

  initial begin
    logic [2:0] modes [6];
    logic [VW-1:0] ev;
    modes[0] = 3'd0; modes[1] = 3'd1; modes[2] = 3'd2;
    modes[3] = 3'd4; modes[4] = 3'd5; modes[5] = 3'd7;
    rst_n = 1'b0; pin = '0; mask = '0; ext_ack = 1'b0; ext_vec = '0;
    m_ready = 1'b0;
    for (int p = 0; p < N; p++) begin
      e_vec[p]  = VW'(8'h30 + p * 4);
      e_dest[p] = DW'(p * 17 + 3);
      e_dm[p]   = 3'd0;
      dstm[p]   = p[0];
      pol[p]    = p[1];
      trig[p]   = p[2];
    end
    pin[0] = 1'b1;
    step(4);
    chk(!m_valid && !ext_req, "R8 reset outputs", {30'd0, m_valid, ext_req}, 32'd0);
    rst_n = 1'b1;
    take_msg(0, 3'd0, e_vec[0], "R8 pin high at reset end");
    quiet(8, "R1 held pin silent");
    pin[0] = 1'b0;
    quiet(6, "R2 lowering silent");

    // Sweep all pins over all delivery modes (R4, R5, R7)
    for (int p = 0; p < N; p++) begin
      for (int k = 0; k < 6; k++) begin
        e_dm[p]  = modes[k];
        e_vec[p] = VW'(8'h30 + p * 4 + k);
        step(1);
        pin[p] = 1'b1;
        if (modes[k] == 3'd7) begin
          ev = VW'(8'hA0 + p * 8 + k);
          ext_serve(ev);
          take_msg(p, modes[k], ev, "R5 external vector");
        end else begin
          take_msg(p, modes[k], e_vec[p], "R4 entry vector");
        end
        pin[p] = 1'b0;
        step(2);
      end
      e_dm[p] = 3'd0;
    end

    // R2 re-raise after lower fires again
    pin[3] = 1'b1;
    take_msg(3, 3'd0, e_vec[3], "R2 first raise");
    pin[3] = 1'b0;
    step(2);
    pin[3] = 1'b1;
    take_msg(3, 3'd0, e_vec[3], "R2 second raise");
    quiet(6, "R1 no refire");
    pin[3] = 1'b0;
    step(2);

    // R3 masked event is lost
    mask[4] = 1'b1;
    step(1);
    pin[4] = 1'b1;
    quiet(8, "R3 masked raise");
    mask[4] = 1'b0;
    quiet(8, "R3 unmask later");
    pin[4] = 1'b0;
    step(2);

    // R6 simultaneous events served in ascending order
    pin[6] = 1'b1; pin[2] = 1'b1; pin[5] = 1'b1;
    take_msg(2, 3'd0, e_vec[2], "R6 first lowest");
    take_msg(5, 3'd0, e_vec[5], "R6 second");
    take_msg(6, 3'd0, e_vec[6], "R6 third");
    quiet(6, "R6 no extra message");
    pin = '0;
    step(2);

    // R6 mixed with external mode on the lower pin
    e_dm[1] = 3'd7;
    pin[1] = 1'b1; pin[7] = 1'b1;
    ext_serve(8'h5C);
    take_msg(1, 3'd7, 8'h5C, "R6 ext first");
    take_msg(7, 3'd0, e_vec[7], "R6 fixed after ext");
    pin = '0;
    step(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule